// File: doc/BRIEF.md
# Idle-Column Rate Compensator

This block carries a stream of aligned 32-bit receive columns (four byte lanes, each with its own control bit) from the recovered receive clock into the local clock domain. The two clocks nominally run at the same rate but may drift apart by a few hundred ppm. A small dual-clock store with Gray-coded pointers sits between them. Each clock domain estimates how full the store is. The input side drops surplus idle columns when the store is running full. The output side repeats an idle column when the store is running dry. Frame columns pass through untouched.

Compensation is switched on by a level input. With the switch off, the store acts as a plain clock-crossing FIFO. If the store still overruns or runs dry, a sticky error flag is raised in the domain that saw it. That domain then moves its own pointer back to the half-full point. After reset the store holds eight idle columns, so reading starts at half full.

Top module: `idle_rate_comp`

## Requirements
- R1: While reset is held, the output column is the idle column (byte 0x07 on every lane, all four control bits set) and both error flags are low.
- R2: With `comp_en` low and equal clocks, the output sequence is exactly eight idle columns followed by the input sequence column for column, with nothing added or dropped.
- R3: With `comp_en` high, every column that is not an idle column leaves the block exactly once, in input order and bit-exact, and none is left behind once the input has idled long enough to drain.
- R4: Only idle columns are ever dropped. When every input gap holds at least two idle columns, every output gap before a start column (lane 0 byte 0xFB with control bit 0 set) also holds at least two idle columns.
- R5: With compensation on and the input clock up to 2 % faster than the output clock, dropping idle columns keeps the overflow flag low.
- R6: With compensation on and the output clock up to 2 % faster, extra idle columns are placed only directly after an idle column, and the underflow flag stays low.
- R7: With compensation off and the input clock clearly faster, `ovf_flag` rises within a few hundred cycles. It then stays high until reset, even after the clocks are made equal again.
- R8: With compensation off and the output clock clearly faster, `unf_flag` rises within a few hundred cycles and stays high until reset, while `ovf_flag` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Recovered receive clock |
| in_rst_n | input | 1 | Asynchronous active-low reset, input domain |
| in_data | input | 32 | Input column bytes, lane 0 in bits 7:0 |
| in_ctrl | input | 4 | Input control bit per lane |
| out_clk | input | 1 | Local clock |
| out_rst_n | input | 1 | Asynchronous active-low reset, output domain |
| comp_en | input | 1 | Level enable for idle insertion and deletion |
| out_data | output | 32 | Output column bytes, local clock domain |
| out_ctrl | output | 4 | Output control bit per lane |
| ovf_flag | output | 1 | Sticky overflow flag, input domain |
| unf_flag | output | 1 | Sticky underflow flag, output domain |

## Verification
A corrupted pointer or a wrong Gray step shows up at the output as a repeated, missing or stale column. The bypass scoreboard catches this in the first column that crosses, about three output cycles after the write. A wrong fill estimate or threshold does not show at once. It shows tens to hundreds of cycles later, as a raised error flag under a 2 % clock offset or as a lost frame column. A deletion rule that ignores the gap length shows as an output gap shorter than two idle columns at the next start column.

// File: rtl/rcomp_pkg.sv
package rcomp_pkg;

  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef struct packed {
    logic [LANES-1:0] ctrl;
    logic [DW-1:0]    data;
  } col_t;

  localparam logic [7:0] IDLE_BYTE = 8'h07;

  function automatic col_t idle_col();
    col_t c;
    c.ctrl = '1;
    c.data = {LANES{IDLE_BYTE}};
    return c;
  endfunction

  function automatic logic col_is_idle(col_t c);
    return (c == idle_col());
  endfunction

endpackage

// File: rtl/rc_gray_sync.sv
module rc_gray_sync #(
  parameter int PW      = 5,
  parameter int RST_BIN = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);

  localparam logic [PW-1:0] RST_B = PW'(RST_BIN);
  localparam logic [PW-1:0] RST_G = RST_B ^ (RST_B >> 1);

  logic [PW-1:0] meta_q;
  logic [PW-1:0] sync_q;

  function automatic logic [PW-1:0] gray_to_bin(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_G;
      sync_q <= RST_G;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  assign bin_out = gray_to_bin(sync_q);

endmodule

// File: rtl/rc_store.sv
module rc_store import rcomp_pkg::*; #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  col_t          wdata,
  input  logic [AW-1:0] raddr,
  output col_t          rdata
);

  col_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= idle_col();
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rc_wr_ctl.sv
module rc_wr_ctl import rcomp_pkg::*; #(
  parameter  int DEPTH    = 16,
  parameter  int HI_MARK  = 10,
  parameter  int SYNC_LAG = 2,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_async,
  input  col_t          in_col,
  input  logic [PW-1:0] rbin_sync,
  output logic          we,
  output logic [AW-1:0] waddr,
  output col_t          wdata,
  output logic [PW-1:0] wgray,
  output logic          ovf_flag
);

  localparam logic [PW-1:0] HALF_P = PW'(DEPTH / 2);
  localparam logic [PW-1:0] FULL_P = PW'(DEPTH);
  localparam logic [PW-1:0] LAG_P  = PW'(SYNC_LAG);
  localparam logic [PW-1:0] HI_P   = PW'(HI_MARK);
  localparam logic [PW-1:0] ONE_P  = PW'(1);

  // Arithmetic kept in functions so it can be restated elsewhere.
  function automatic logic [PW-1:0] occupancy(logic [PW-1:0] head, logic [PW-1:0] tail);
    return head - tail;
  endfunction

  // The synchronized read pointer is stale, so the raw level reads high.
  function automatic logic [PW-1:0] level_est(logic [PW-1:0] raw);
    return (raw > LAG_P) ? raw - LAG_P : '0;
  endfunction

  function automatic logic [PW-1:0] bin_to_gray(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic          en_m, en_q;
  logic [PW-1:0] wbin, wbin_nx;
  logic [PW-1:0] fill_raw, fill_est;
  logic [1:0]    idle_run;
  logic [1:0]    idle_run_nx;
  logic          col_idle;
  logic          del_evt;
  logic          ovf_evt;

  always_comb begin
    col_idle = col_is_idle(in_col);
    fill_raw = occupancy(wbin, rbin_sync);
    fill_est = level_est(fill_raw);
    // Two idle columns of this gap are already stored ahead of this one.
    del_evt  = en_q && col_idle && idle_run[1] && (fill_est > HI_P);
    ovf_evt  = !del_evt && (fill_raw >= FULL_P);
    we       = !del_evt && !ovf_evt;
    if (ovf_evt)  wbin_nx = rbin_sync + HALF_P;
    else if (we)  wbin_nx = wbin + ONE_P;
    else          wbin_nx = wbin;
    if (ovf_evt)
      idle_run_nx = 2'd0;
    else if (!we)
      idle_run_nx = idle_run;
    else if (!col_idle)
      idle_run_nx = 2'd0;
    else if (idle_run[1])
      idle_run_nx = idle_run;
    else
      idle_run_nx = idle_run + 2'd1;
  end

  assign waddr = wbin[AW-1:0];
  assign wdata = in_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_m     <= 1'b0;
      en_q     <= 1'b0;
      wbin     <= HALF_P;
      wgray    <= bin_to_gray(HALF_P);
      idle_run <= 2'd0;
      ovf_flag <= 1'b0;
    end else begin
      en_m     <= en_async;
      en_q     <= en_m;
      wbin     <= wbin_nx;
      wgray    <= bin_to_gray(wbin_nx);
      idle_run <= idle_run_nx;
      if (ovf_evt) ovf_flag <= 1'b1;
    end
  end

  // R4: a dropped column leaves the write pointer where it was
  a_r4_drop_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    del_evt |=> (wbin == $past(wbin)));

  // R2: with compensation off every column advances the write pointer by one
  a_r2_bypass_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ovf_evt) |=> (wbin == $past(wbin) + ONE_P));

  // R7: overflow flag is sticky
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  // R3: the published pointer moves by at most one Gray bit outside a recentre
  a_r3_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_evt |=> $onehot0(wgray ^ $past(wgray)));

endmodule

// File: rtl/rc_rd_ctl.sv
module rc_rd_ctl import rcomp_pkg::*; #(
  parameter  int DEPTH    = 16,
  parameter  int LO_MARK  = 6,
  parameter  int SYNC_LAG = 2,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_async,
  input  col_t          mem_rdata,
  input  logic [PW-1:0] wbin_sync,
  output logic [AW-1:0] raddr,
  output col_t          out_col,
  output logic [PW-1:0] rgray,
  output logic          unf_flag
);

  localparam logic [PW-1:0] HALF_P = PW'(DEPTH / 2);
  localparam logic [PW-1:0] LAG_P  = PW'(SYNC_LAG);
  localparam logic [PW-1:0] LO_P   = PW'(LO_MARK);
  localparam logic [PW-1:0] ONE_P  = PW'(1);

  function automatic logic [PW-1:0] occupancy(logic [PW-1:0] head, logic [PW-1:0] tail);
    return head - tail;
  endfunction

  // The synchronized write pointer is stale, so the raw level reads low.
  function automatic logic [PW-1:0] level_est(logic [PW-1:0] raw);
    return raw + LAG_P;
  endfunction

  function automatic logic [PW-1:0] bin_to_gray(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic          en_m, en_q;
  logic [PW-1:0] rbin, rbin_nx;
  logic [PW-1:0] fill_raw, fill_est;
  logic          ins_evt;
  logic          unf_evt;
  logic          take;

  always_comb begin
    fill_raw = occupancy(wbin_sync, rbin);
    fill_est = level_est(fill_raw);
    // Repeat an idle column only right after an idle column went out.
    ins_evt  = en_q && col_is_idle(out_col) && (fill_est < LO_P);
    unf_evt  = !ins_evt && (fill_raw == '0);
    take     = !ins_evt && !unf_evt;
    if (unf_evt)   rbin_nx = wbin_sync - HALF_P;
    else if (take) rbin_nx = rbin + ONE_P;
    else           rbin_nx = rbin;
  end

  assign raddr = rbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_m     <= 1'b0;
      en_q     <= 1'b0;
      rbin     <= '0;
      rgray    <= '0;
      out_col  <= idle_col();
      unf_flag <= 1'b0;
    end else begin
      en_m     <= en_async;
      en_q     <= en_m;
      rbin     <= rbin_nx;
      rgray    <= bin_to_gray(rbin_nx);
      out_col  <= take ? mem_rdata : idle_col();
      if (unf_evt) unf_flag <= 1'b1;
    end
  end

  // R6: an inserted column is an idle column and the read pointer holds
  a_r6_insert_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ins_evt |=> (col_is_idle(out_col) && rbin == $past(rbin)));

  // R2: with compensation off every read advances the read pointer by one
  a_r2_bypass_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !unf_evt) |=> (rbin == $past(rbin) + ONE_P));

  // R8: underflow flag is sticky
  a_r8_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> unf_flag);

  // R3: read pointer Gray code moves by at most one bit outside a recentre
  a_r3_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    !unf_evt |=> $onehot0(rgray ^ $past(rgray)));

endmodule

// File: rtl/idle_rate_comp.sv
module idle_rate_comp import rcomp_pkg::*; #(
  parameter int DEPTH    = 16,
  parameter int HI_MARK  = 10,
  parameter int LO_MARK  = 6,
  parameter int SYNC_LAG = 2
) (
  input  logic        in_clk,
  input  logic        in_rst_n,
  input  logic [31:0] in_data,
  input  logic [3:0]  in_ctrl,
  input  logic        out_clk,
  input  logic        out_rst_n,
  input  logic        comp_en,
  output logic [31:0] out_data,
  output logic [3:0]  out_ctrl,
  output logic        ovf_flag,
  output logic        unf_flag
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  col_t          in_col, out_col, wdata, rdata;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray;
  logic [PW-1:0] rbin_at_wr, wbin_at_rd;

  always_comb begin
    in_col.ctrl = in_ctrl;
    in_col.data = in_data;
  end

  assign out_data = out_col.data;
  assign out_ctrl = out_col.ctrl;

  rc_store #(.DEPTH(DEPTH)) u_store (
    .clk   (in_clk),
    .rst_n (in_rst_n),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  rc_gray_sync #(.PW(PW), .RST_BIN(0)) u_rptr_sync (
    .clk     (in_clk),
    .rst_n   (in_rst_n),
    .gray_in (rgray),
    .bin_out (rbin_at_wr)
  );

  rc_gray_sync #(.PW(PW), .RST_BIN(DEPTH / 2)) u_wptr_sync (
    .clk     (out_clk),
    .rst_n   (out_rst_n),
    .gray_in (wgray),
    .bin_out (wbin_at_rd)
  );

  rc_wr_ctl #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .SYNC_LAG(SYNC_LAG)) u_wr (
    .clk       (in_clk),
    .rst_n     (in_rst_n),
    .en_async  (comp_en),
    .in_col    (in_col),
    .rbin_sync (rbin_at_wr),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata),
    .wgray     (wgray),
    .ovf_flag  (ovf_flag)
  );

  rc_rd_ctl #(.DEPTH(DEPTH), .LO_MARK(LO_MARK), .SYNC_LAG(SYNC_LAG)) u_rd (
    .clk       (out_clk),
    .rst_n     (out_rst_n),
    .en_async  (comp_en),
    .mem_rdata (rdata),
    .wbin_sync (wbin_at_rd),
    .raddr     (raddr),
    .out_col   (out_col),
    .rgray     (rgray),
    .unf_flag  (unf_flag)
  );

endmodule

// File: tb/sim_idle_rate_comp.sv
`timescale 1ns/1ps
module sim_idle_rate_comp;

  localparam logic [35:0] IDLE_W = {4'hF, 32'h07070707};

  logic        wclk = 1'b0;
  logic        rclk = 1'b0;
  real         wh = 2.0;
  real         rh = 2.0;
  logic        in_rst_n  = 1'b0;
  logic        out_rst_n = 1'b0;
  logic        comp_en   = 1'b0;
  logic [31:0] in_data   = 32'h07070707;
  logic [3:0]  in_ctrl   = 4'hF;
  logic [31:0] out_data;
  logic [3:0]  out_ctrl;
  logic        ovf_flag, unf_flag;

  initial forever #(wh) wclk = ~wclk;
  initial forever #(rh) rclk = ~rclk;

  idle_rate_comp u0 (
    .in_clk(wclk), .in_rst_n(in_rst_n), .in_data(in_data), .in_ctrl(in_ctrl),
    .out_clk(rclk), .out_rst_n(out_rst_n), .comp_en(comp_en),
    .out_data(out_data), .out_ctrl(out_ctrl),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  logic [35:0] exp_q[$];
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          stop_mon = 1'b0;
  bit          bypass   = 1'b0;
  logic [31:0] rng = 32'h1ACE5EED;

  function automatic logic [31:0] nxt(logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: applies one column per input cycle and records what must come out.
  task automatic put(input logic [35:0] c);
    {in_ctrl, in_data} = c;
    if (bypass || c != IDLE_W) exp_q.push_back(c);
    @(negedge wclk);
  endtask

  task automatic drive_frames(input int nframes);
    for (int f = 0; f < nframes; f++) begin
      int len;
      int gap;
      rng = nxt(rng);
      len = 1 + int'(rng[2:0]);
      gap = 2 + int'(rng[5:4]);
      put({4'b0001, rng[31:8], 8'hFB});
      for (int k = 0; k < len; k++) begin
        rng = nxt(rng);
        put({4'h0, rng});
      end
      put({4'hF, 24'h070707, 8'hFD});
      for (int k = 0; k < gap; k++) put(IDLE_W);
    end
    repeat (60) put(IDLE_W);
    stop_mon = 1'b1;
  endtask

  // Monitor: pops expected columns as the output produces them.
  task automatic monitor();
    int          run  = 0;
    bit          seen = 1'b0;
    logic [35:0] c, e;
    while (!stop_mon) begin
      @(negedge rclk);
      c = {out_ctrl, out_data};
      if (bypass) begin
        if (exp_q.size() == 0) chk(1'b0, "R2", "column with nothing expected", c, IDLE_W);
        else begin
          e = exp_q.pop_front();
          chk(c == e, "R2", "bypass column", c, e);
        end
      end else if (c == IDLE_W) begin
        run++;
      end else begin
        if (c[32] && c[7:0] == 8'hFB) begin
          if (seen) chk(run >= 2, "R4", "idle columns in gap", 36'(run), 36'd2);
          seen = 1'b1;
        end
        run = 0;
        if (exp_q.size() == 0) chk(1'b0, "R3", "frame column with nothing expected", c, '0);
        else begin
          e = exp_q.pop_front();
          chk(c == e, "R3", "frame column", c, e);
        end
      end
    end
  endtask

  task automatic hold_reset(input bit byp, input real w_half, input real r_half);
    bypass   = byp;
    comp_en  = !byp;
    wh       = w_half;
    rh       = r_half;
    stop_mon = 1'b0;
    exp_q.delete();
    in_rst_n  = 1'b0;
    out_rst_n = 1'b0;
    {in_ctrl, in_data} = IDLE_W;
    repeat (4) @(negedge wclk);
    chk({out_ctrl, out_data} == IDLE_W, "R1", "output during reset", {out_ctrl, out_data}, IDLE_W);
    chk(!ovf_flag && !unf_flag, "R1", "flags during reset", {34'd0, ovf_flag, unf_flag}, '0);
  endtask

  task automatic run_phase(input bit byp, input real w_half, input real r_half, input int nframes);
    hold_reset(byp, w_half, r_half);
    if (byp) repeat (8) exp_q.push_back(IDLE_W);
    fork
      begin @(negedge wclk); in_rst_n = 1'b1; drive_frames(nframes); end
      begin @(negedge rclk); out_rst_n = 1'b1; monitor(); end
    join
    if (!byp) begin
      chk(exp_q.size() == 0, "R3", "columns not delivered", 36'(exp_q.size()), '0);
      chk(!ovf_flag, "R5", "overflow flag with compensation on", {35'd0, ovf_flag}, '0);
      chk(!unf_flag, "R6", "underflow flag with compensation on", {35'd0, unf_flag}, '0);
    end
  endtask

  task automatic err_phase(input bit over);
    hold_reset(1'b1, over ? 2.0 : 3.0, over ? 3.0 : 2.0);
    fork
      begin @(negedge wclk); in_rst_n = 1'b1; end
      begin @(negedge rclk); out_rst_n = 1'b1; end
    join
    repeat (300) @(negedge wclk);
    if (over) begin
      chk(ovf_flag, "R7", "overflow flag raised", {35'd0, ovf_flag}, 36'd1);
    end else begin
      chk(unf_flag, "R8", "underflow flag raised", {35'd0, unf_flag}, 36'd1);
      chk(!ovf_flag, "R8", "overflow flag while draining", {35'd0, ovf_flag}, '0);
    end
    wh = 2.0;
    rh = 2.0;
    repeat (100) @(negedge wclk);
    if (over) chk(ovf_flag, "R7", "overflow flag sticky", {35'd0, ovf_flag}, 36'd1);
    else      chk(unf_flag, "R8", "underflow flag sticky", {35'd0, unf_flag}, 36'd1);
  endtask

  initial begin
    #(700us);
    n_fail++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    run_phase(1'b1, 2.0, 2.0, 100);   // R2 bypass, equal clocks
    run_phase(1'b0, 2.0, 2.04, 300);  // R5 input 2 % faster: deletions
    run_phase(1'b0, 2.04, 2.0, 300);  // R6 output 2 % faster: insertions
    err_phase(1'b1);                  // R7
    err_phase(1'b0);                  // R8
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule